// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block resolves interrupt priority from a table that software loads. The table has 40 slots. Each slot holds a valid flag and a 6-bit source number. A slot's position sets its rank, and slot 0 ranks highest. Each cycle the block takes two vectors from outside: the per-source "active" vector (pending and enabled, already combined) and the per-source steering vector that sends a source to the fast (FIQ) or normal (IRQ) request line. From these it finds, separately for each line, the highest-ranked slot whose source is active on that line.

Both winners are packed into one 32-bit status word. The word is registered on `status_o` every cycle. It can also be read through the register port at offset 0x18, where it is sampled at the moment of the read. Slots are written and read through the same word-aligned register port. Slots 0–31 are at 0x1C + 4k and slots 32–39 are at 0xB0 + 4(k−32).

Top module: `prio_resolver`

## Requirements
- R1: Synchronous active-high reset clears every slot to zero, so every slot is invalid. It also sets `status_o` to 0x003F003F and `rdata_o` to 0.
- R2: A slot write keeps only bit 31 (valid) and bits 5:0 (source number). Reading the slot back returns the written value ANDed with 0x8000003F.
- R3: Slot k is at byte offset 0x1C + 4k for k = 0..31 and at 0xB0 + 4(k−32) for k = 32..39. A write to any other offset changes no slot, and that includes unaligned offsets. A read of an offset that is neither a slot nor 0x18 returns 0.
- R4: A slot competes only when its valid bit (bit 31) is 1 and its source number is below 40.
- R5: A competing slot is a candidate only when `active_i[source]` is 1. If `fiq_sel_i[source]` is 1 the slot competes for FIQ; if it is 0 the slot competes for IRQ.
- R6: On each line, the candidate with the lowest slot index wins, whatever its source number. The FIQ and IRQ lines are resolved independently of each other.
- R7: The status word carries the IRQ valid flag in bit 31, the IRQ source in bits 21:16, the FIQ valid flag in bit 15 and the FIQ source in bits 5:0. All other bits are 0.
- R8: A line with no winner shows valid 0 and source field 0x3F.
- R9: A read at offset 0x18 returns the status word for the table and inputs at the read edge. A write to 0x18 has no effect.
- R10: `status_o` follows a change of the inputs or of the table one clock edge later and holds its value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| active_i | input | 40 | Per-source pending-and-enabled vector |
| fiq_sel_i | input | 40 | Per-source steering, 1 = FIQ, 0 = IRQ |
| rdata_o | output | 32 | Read data, registered on the edge where `rd_en` is sampled |
| status_o | output | 32 | Registered packed winner word |

## Verification
Slots are loaded so that rank order and source-number order disagree. For example, source 39 is placed in slot 0 and source 0 in slot 1, which separates a correct slot-rank search from a search by source number. Invalid slots, out-of-range source numbers and inactive sources are mixed in among valid candidates, to show that each filter on its own removes a slot from the contest. The steering vector is flipped while the table stays the same, so both lines are seen to resolve at once and from different slots. Writes to unmapped, unaligned and status offsets are followed by a full-active contest, which would expose any stray slot such a write might have changed.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
  localparam int ID_W   = 6;
  localparam int WORD_W = 32;
  localparam int SLOT_W = ID_W + 1;
  localparam logic [ID_W-1:0] NO_ID = '1;

  typedef struct packed {
    logic            valid;
    logic [ID_W-1:0] src;
  } slot_t;

  function automatic logic [WORD_W-1:0] pack_status(
      input logic irq_v, input logic [ID_W-1:0] irq_id,
      input logic fiq_v, input logic [ID_W-1:0] fiq_id);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[31]    = irq_v;
    w[21:16] = irq_id;
    w[15]    = fiq_v;
    w[5:0]   = fiq_id;
    return w;
  endfunction
endpackage

// File: rtl/prio_res_addr_dec.sv
module prio_res_addr_dec #(
  parameter int ADDR_W      = 8,
  parameter int NUM_ENTRIES = 40,
  parameter int LO_COUNT    = 32,
  parameter int LO_BASE     = 'h1C,
  parameter int HI_BASE     = 'hB0,
  parameter int STATUS_OFF  = 'h18,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              slot_hit,
  output logic [IDX_W-1:0]  slot_idx,
  output logic              status_hit
);
  localparam int HI_COUNT = NUM_ENTRIES - LO_COUNT;

  always_comb begin
    int unsigned a;
    a          = 32'(addr);
    slot_hit   = 1'b0;
    slot_idx   = '0;
    status_hit = (a == STATUS_OFF);
    if (a[1:0] == 2'b00) begin
      if (a >= LO_BASE && a < LO_BASE + 4 * LO_COUNT) begin
        slot_hit = 1'b1;
        slot_idx = IDX_W'((a - LO_BASE) >> 2);
      end else if (a >= HI_BASE && a < HI_BASE + 4 * HI_COUNT) begin
        slot_hit = 1'b1;
        slot_idx = IDX_W'(LO_COUNT + ((a - HI_BASE) >> 2));
      end
    end
  end
endmodule

// File: rtl/prio_res_table.sv
module prio_res_table
  import prio_res_pkg::*;
#(
  parameter int NUM_ENTRIES = 40,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [IDX_W-1:0]                widx,
  input  slot_t                           wslot,
  input  logic [IDX_W-1:0]                ridx,
  output slot_t                           rslot,
  output logic [NUM_ENTRIES*SLOT_W-1:0]   slots_flat
);
  slot_t mem [NUM_ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_ENTRIES; k++) mem[k] <= '0;
    end else if (we) begin
      mem[widx] <= wslot;
    end
  end

  assign rslot = mem[ridx];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_flat
    assign slots_flat[g*SLOT_W +: SLOT_W] = mem[g];
  end

  // R2: a write lands exactly in the addressed slot
  assert_slot_written_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(widx)] == $past(wslot));
endmodule

// File: rtl/prio_res_chain.sv
module prio_res_chain
  import prio_res_pkg::*;
#(
  parameter int NUM_ENTRIES = 40,
  parameter bit WANT_FIQ    = 1'b0,
  localparam int PAD_W      = 2 ** ID_W
) (
  input  logic [NUM_ENTRIES*SLOT_W-1:0] slots_flat,
  input  logic [NUM_ENTRIES-1:0]        active,
  input  logic [NUM_ENTRIES-1:0]        steer,
  output logic                          win_v,
  output logic [ID_W-1:0]               win_id
);
  logic [PAD_W-1:0] act_pad, steer_pad;
  assign act_pad   = PAD_W'(active);
  assign steer_pad = PAD_W'(steer);

  // Walk from lowest rank to highest so the lowest slot index is left standing.
  always_comb begin
    slot_t s;
    win_v  = 1'b0;
    win_id = NO_ID;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      s = slot_t'(slots_flat[k*SLOT_W +: SLOT_W]);
      if (s.valid && (int'(s.src) < NUM_ENTRIES) && act_pad[s.src] &&
          (steer_pad[s.src] == WANT_FIQ)) begin
        win_v  = 1'b1;
        win_id = s.src;
      end
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_res_pkg::*;
#(
  parameter int NUM_ENTRIES = 40,
  parameter int LO_COUNT    = 32,
  parameter int ADDR_W      = 8,
  parameter int LO_BASE     = 'h1C,
  parameter int HI_BASE     = 'hB0,
  parameter int STATUS_OFF  = 'h18
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [WORD_W-1:0]      wdata,
  input  logic [NUM_ENTRIES-1:0] active_i,
  input  logic [NUM_ENTRIES-1:0] fiq_sel_i,
  output logic [WORD_W-1:0]      rdata_o,
  output logic [WORD_W-1:0]      status_o
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int PAD_W = 2 ** ID_W;
  localparam logic [WORD_W-1:0] IDLE_WORD = pack_status(1'b0, NO_ID, 1'b0, NO_ID);

  logic                          slot_hit, status_hit;
  logic [IDX_W-1:0]              slot_idx;
  slot_t                         wslot, rslot;
  logic [NUM_ENTRIES*SLOT_W-1:0] slots_flat;
  logic [1:0]                    win_v;
  logic [ID_W-1:0]               win_id [2];
  logic [WORD_W-1:0]             status_now;

  prio_res_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .LO_COUNT(LO_COUNT),
    .LO_BASE(LO_BASE), .HI_BASE(HI_BASE), .STATUS_OFF(STATUS_OFF)
  ) dec_i (
    .addr(addr), .slot_hit(slot_hit), .slot_idx(slot_idx), .status_hit(status_hit)
  );

  assign wslot.valid = wdata[WORD_W-1];
  assign wslot.src   = wdata[ID_W-1:0];

  prio_res_table #(.NUM_ENTRIES(NUM_ENTRIES)) table_i (
    .clk(clk), .rst(rst), .we(wr_en && slot_hit), .widx(slot_idx), .wslot(wslot),
    .ridx(slot_idx), .rslot(rslot), .slots_flat(slots_flat)
  );

  // index 0 resolves the normal line, index 1 the fast line
  for (genvar g = 0; g < 2; g++) begin : g_line
    prio_res_chain #(.NUM_ENTRIES(NUM_ENTRIES), .WANT_FIQ(g == 1)) chain_i (
      .slots_flat(slots_flat), .active(active_i), .steer(fiq_sel_i),
      .win_v(win_v[g]), .win_id(win_id[g])
    );
  end

  assign status_now = pack_status(win_v[0], win_id[0], win_v[1], win_id[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= IDLE_WORD;
      rdata_o  <= '0;
    end else begin
      status_o <= status_now;
      if (rd_en) begin
        if (status_hit)    rdata_o <= status_now;
        else if (slot_hit) rdata_o <= {rslot.valid, {(WORD_W-SLOT_W){1'b0}}, rslot.src};
        else               rdata_o <= '0;
      end
    end
  end

  logic [PAD_W-1:0] act_pad, sel_pad;
  assign act_pad = PAD_W'(active_i);
  assign sel_pad = PAD_W'(fiq_sel_i);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_o == 32'h003F003F && rdata_o == '0));
  assert_unmapped_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !slot_hit && !status_hit) |=> rdata_o == '0);
  assert_fiq_source_R5: assert property (@(posedge clk) disable iff (rst)
    win_v[1] |-> (act_pad[win_id[1]] && sel_pad[win_id[1]] && int'(win_id[1]) < NUM_ENTRIES));
  assert_irq_source_R5: assert property (@(posedge clk) disable iff (rst)
    win_v[0] |-> (act_pad[win_id[0]] && !sel_pad[win_id[0]] && int'(win_id[0]) < NUM_ENTRIES));
  assert_irq_empty_R8: assert property (@(posedge clk) disable iff (rst)
    !status_o[31] |-> status_o[21:16] == 6'h3F);
  assert_fiq_empty_R8: assert property (@(posedge clk) disable iff (rst)
    !status_o[15] |-> status_o[5:0] == 6'h3F);
endmodule

// File: tb/prio_resolver_tb.sv
module prio_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [39:0] active_i = '0, fiq_sel_i = '0;
  logic [31:0] rdata_o, status_o;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  prio_resolver dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .active_i(active_i), .fiq_sel_i(fiq_sel_i), .rdata_o(rdata_o), .status_o(status_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; active_i = '0; fiq_sel_i = '0;
    settle(); rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata_o;
  endtask

  task automatic vecs(input logic [39:0] act, input logic [39:0] sel);
    @(negedge clk); active_i = act; fiq_sel_i = sel;
    settle();
  endtask

  task automatic t_masking();
    do_reset();
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, rv); check("R2 all-ones write", rv, 32'h8000_003F);
    wr(8'hCC, 32'h1234_5678); rd(8'hCC, rv); check("R2 slot 39 masked", rv, 32'h0000_0038);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 status after reset", status_o, 32'h003F_003F);
    check("R1 rdata after reset", rdata_o, 32'h0);
    rd(8'h1C, rv); check("R1 slot 0 cleared", rv, 32'h0);
    rd(8'hCC, rv); check("R1 slot 39 cleared", rv, 32'h0);
  endtask

  task automatic t_addr_map();
    do_reset();
    wr(8'h30, 32'h8000_0007); rd(8'h30, rv); check("R3 slot 5 readback", rv, 32'h8000_0007);
    wr(8'hB0, 32'h8000_0021); rd(8'hB0, rv); check("R3 slot 32 readback", rv, 32'h8000_0021);
    wr(8'h9C, 32'h8000_000A); rd(8'h9C, rv); check("R3 gap offset reads 0", rv, 32'h0);
    wr(8'h1D, 32'h8000_000B); rd(8'h1C, rv); check("R3 unaligned write ignored", rv, 32'h0);
    vecs('1, '0);
    check("R3 no stray slot in contest", status_o, 32'h8007_003F);
    wr(8'h18, 32'hFFFF_FFFF); settle();
    check("R9 write to status ignored", status_o, 32'h8007_003F);
    rd(8'h18, rv); check("R9 status read", rv, 32'h8007_003F);
    @(negedge clk); active_i = '0;
    check("R10 holds before edge", status_o, 32'h8007_003F);
    settle();
    check("R10 follows after edge", status_o, 32'h003F_003F);
  endtask

  task automatic t_participation();
    do_reset();
    wr(8'h1C, 32'h8000_0028);   // source 40: out of range
    wr(8'h20, 32'h0000_0003);   // valid bit clear
    wr(8'h24, 32'h8000_0007);
    vecs('1, '0);
    check("R4 invalid and out-of-range skipped (IRQ)", status_o, 32'h8007_003F);
    vecs('1, '1);
    check("R4 invalid and out-of-range skipped (FIQ)", status_o, 32'h003F_8007);
  endtask

  task automatic t_steering();
    do_reset();
    wr(8'h1C, 32'h8000_000A); wr(8'h20, 32'h8000_0014); wr(8'h24, 32'h8000_001E);
    vecs((40'd1 << 10) | (40'd1 << 20) | (40'd1 << 30), 40'd1 << 20);
    check("R5 R6 R7 both lines independent", status_o, 32'h800A_8014);
    vecs((40'd1 << 20) | (40'd1 << 30), 40'd1 << 20);
    check("R5 inactive source drops out", status_o, 32'h801E_8014);
    vecs((40'd1 << 20) | (40'd1 << 30), '0);
    check("R5 R8 steering to IRQ empties FIQ", status_o, 32'h8014_003F);
  endtask

  task automatic t_rank();
    do_reset();
    wr(8'h1C, 32'h8000_0027); wr(8'h20, 32'h8000_0000);
    vecs((40'd1 << 39) | 40'd1, '0);
    check("R6 slot rank beats source number", status_o, 32'h8027_003F);
    vecs(40'd1, '0);
    check("R6 source 0 in slot 1", status_o, 32'h8000_003F);
    wr(8'h1C, 32'h0); wr(8'h20, 32'h0); wr(8'hCC, 32'h8000_0005);
    vecs(40'd1 << 5, 40'd1 << 5);
    check("R6 last slot can win", status_o, 32'h003F_8005);
  endtask

  initial begin
    fork
      begin
        settle(); settle();
        t_masking();
        t_reset();
        t_addr_map();
        t_participation();
        t_steering();
        t_rank();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule